// File: doc/BRIEF.md
# Clock-Activity Power and Mode Controller

This block sits beside the timing logic of a voice-band PCM converter. It watches four slow pins for activity: the transmit frame sync, the receive frame sync, a dual-purpose pin that is either a receive master clock or a power-down level, and a receive bit-clock pin that may instead be strapped to a fixed level. All four pins are brought into the reference clock domain through synchronizers. Within each fixed window of reference cycles, every pin is classed as toggling or static. A pin is static if no edge reached it during the whole window. A static pin is held at its last level.

Once per window the block forms a candidate operating state from the four classifications. The state has three parts: a power/mode code, which master clock should drive internal timing, and a master-clock frequency code. The frequency code is decoded from the bit-clock pin when that pin is strapped. A candidate is committed to the outputs only when two evaluations in a row agree. This keeps a brief pause on a frame sync from switching the mode. The clock dividers that use these outputs live elsewhere. All ports are plain control and status levels, so there is no stream interface and no back-pressure.

Top module: `pm_clock_mode_ctrl`

## Requirements
- R1: During and straight after reset the outputs are pwr_up = 0, mode = 2'b00, clk_src_rx = 0 and freq_code = 2'b00.
- R2: A pin counts as toggling for an evaluation if its synchronized value showed at least one edge during the preceding window of WINDOW reference cycles. Otherwise it counts as static at its last sampled level.
- R3: When the transmit frame sync toggles and the power-down pin is not static high, the committed state is full duplex. This means mode = 2'b01, pwr_up = 1 and clk_src_rx = 0 (transmit master clock), whatever the receive frame sync and the power-down pin are doing.
- R4: When the transmit frame sync is static, the receive frame sync toggles and the power-down pin is not static high, the committed state is receive half-channel. This means mode = 2'b10 and pwr_up = 1. clk_src_rx = 1 only if the power-down pin is toggling, which means it is acting as the receive master clock.
- R5: A power-down pin that is static high gives mode = 2'b00, pwr_up = 0 and clk_src_rx = 0, even while frame syncs toggle.
- R6: When neither frame sync toggles, the state is powered down (mode = 2'b00, pwr_up = 0, clk_src_rx = 0).
- R7: The freq_code output has three values. A bit-clock pin that is static low gives 2'b01, meaning a 1.536/1.544 MHz master clock. A pin that is static high gives 2'b10, meaning 2.048 MHz. A toggling pin gives 2'b00, meaning separate bit clocks with no strap decoded.
- R8: A new state reaches the outputs only after two consecutive evaluations produce it. A deviation that lasts for a single evaluation leaves the outputs unchanged. The outputs change only in the cycle after an evaluation.
- R9: mode never takes the value 2'b11, and pwr_up is 1 exactly when mode is not 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for the activity windows |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_fsync | input | 1 | Transmit frame sync pin (asynchronous) |
| rx_fsync | input | 1 | Receive frame sync pin (asynchronous) |
| rx_mclk_pdn | input | 1 | Receive master clock or power-down level (asynchronous) |
| rx_bclk_sel | input | 1 | Receive bit clock, or a strapped level that selects the frequency (asynchronous) |
| pwr_up | output | 1 | Device powered up |
| mode | output | 2 | 00 powered down, 01 full duplex, 10 receive half-channel |
| clk_src_rx | output | 1 | 1: receive master clock drives timing; 0: transmit master clock |
| freq_code | output | 2 | 00 none, 01 1.536/1.544 MHz, 10 2.048 MHz |

## Verification
Some properties are checked by assertions on every cycle. The mode code is never illegal, and the power flag always agrees with the mode. Outputs hold steady except in the cycle after an evaluation. Full duplex and power-down always select the transmit master clock, and the frequency code never takes its unused value. Other behaviour can only be shown by the bench scenarios, which compare the settled outputs against expected values:

- the decision table that maps pin activity to mode, clock source and frequency;
- that a frame-sync pause shorter than two windows is absorbed;
- that a real stop is committed no sooner than two windows later.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
package pm_pkg;
  typedef enum logic [1:0] {
    MODE_DOWN   = 2'b00,
    MODE_DUPLEX = 2'b01,
    MODE_HALF   = 2'b10
  } pm_mode_e;

  typedef enum logic [1:0] {
    FREQ_NONE = 2'b00,
    FREQ_LOW  = 2'b01,
    FREQ_HIGH = 2'b10
  } pm_freq_e;

  typedef struct packed {
    pm_mode_e mode;
    logic     src_rx;
    pm_freq_e freq;
  } pm_state_t;

  localparam int NUM_WATCH = 4;
  localparam int W_TXFS = 0;
  localparam int W_RXFS = 1;
  localparam int W_PDN  = 2;
  localparam int W_BSEL = 3;

  localparam pm_state_t PM_RESET_STATE = '{mode: MODE_DOWN, src_rx: 1'b0, freq: FREQ_NONE};
endpackage

// File: rtl/pm_pin_sync.sv
`timescale 1ns/1ps
module pm_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic pin_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], pin_in};
  end

  assign pin_out = chain[STAGES-1];
endmodule

// File: rtl/pm_window_timer.sv
`timescale 1ns/1ps
module pm_window_timer #(
  parameter int WINDOW = 256
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_end,
  output logic eval_tick
);
  localparam int CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      eval_tick <= 1'b0;
    end else begin
      count     <= (count == LAST) ? '0 : count + 1'b1;
      eval_tick <= (count == LAST);
    end
  end

  assign win_end = (count == LAST);
endmodule

// File: rtl/pm_activity_mon.sv
`timescale 1ns/1ps
module pm_activity_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_s,
  input  logic win_end,
  output logic active,
  output logic level
);
  logic seen;
  logic edge_now;

  assign edge_now = sig_s ^ level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level  <= 1'b0;
      seen   <= 1'b0;
      active <= 1'b0;
    end else begin
      level <= sig_s;
      if (win_end) begin
        active <= seen | edge_now;
        seen   <= 1'b0;
      end else if (edge_now) begin
        seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pm_mode_decider.sv
`timescale 1ns/1ps
module pm_mode_decider
  import pm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 eval_tick,
  input  logic [NUM_WATCH-1:0] active,
  input  logic [NUM_WATCH-1:0] level,
  output pm_state_t            state_q,
  output logic                 pwr_q
);
  pm_state_t cand;
  pm_state_t last_cand;
  logic      pdn_held_high;
  logic      no_fsync;

  assign pdn_held_high = !active[W_PDN] && level[W_PDN];
  assign no_fsync      = !active[W_TXFS] && !active[W_RXFS];

  always_comb begin
    cand = PM_RESET_STATE;
    if (pdn_held_high || no_fsync) begin
      cand.mode   = MODE_DOWN;
      cand.src_rx = 1'b0;
    end else if (active[W_TXFS]) begin
      cand.mode   = MODE_DUPLEX;
      cand.src_rx = 1'b0;
    end else begin
      cand.mode   = MODE_HALF;
      cand.src_rx = active[W_PDN];
    end
    if (active[W_BSEL])     cand.freq = FREQ_NONE;
    else if (level[W_BSEL]) cand.freq = FREQ_HIGH;
    else                    cand.freq = FREQ_LOW;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_cand <= PM_RESET_STATE;
      state_q   <= PM_RESET_STATE;
      pwr_q     <= 1'b0;
    end else if (eval_tick) begin
      last_cand <= cand;
      if (cand == last_cand) begin
        state_q <= cand;
        pwr_q   <= (cand.mode != MODE_DOWN);
      end
    end
  end
endmodule

// File: rtl/pm_clock_mode_ctrl.sv
`timescale 1ns/1ps
module pm_clock_mode_ctrl
  import pm_pkg::*;
#(
  parameter int WINDOW      = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_fsync,
  input  logic       rx_fsync,
  input  logic       rx_mclk_pdn,
  input  logic       rx_bclk_sel,
  output logic       pwr_up,
  output logic [1:0] mode,
  output logic       clk_src_rx,
  output logic [1:0] freq_code
);
  logic [NUM_WATCH-1:0] pins_raw;
  logic [NUM_WATCH-1:0] pins_s;
  logic [NUM_WATCH-1:0] act;
  logic [NUM_WATCH-1:0] lvl;
  logic                 win_end;
  logic                 eval_tick;
  pm_state_t            state_q;
  logic                 pwr_q;

  assign pins_raw[W_TXFS] = tx_fsync;
  assign pins_raw[W_RXFS] = rx_fsync;
  assign pins_raw[W_PDN]  = rx_mclk_pdn;
  assign pins_raw[W_BSEL] = rx_bclk_sel;

  pm_window_timer #(.WINDOW(WINDOW)) u_timer (
    .clk(clk), .rst_n(rst_n), .win_end(win_end), .eval_tick(eval_tick)
  );

  for (genvar g = 0; g < NUM_WATCH; g++) begin : g_watch
    pm_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_in(pins_raw[g]), .pin_out(pins_s[g])
    );
    pm_activity_mon u_mon (
      .clk(clk), .rst_n(rst_n), .sig_s(pins_s[g]), .win_end(win_end),
      .active(act[g]), .level(lvl[g])
    );
  end

  pm_mode_decider u_dec (
    .clk(clk), .rst_n(rst_n), .eval_tick(eval_tick),
    .active(act), .level(lvl), .state_q(state_q), .pwr_q(pwr_q)
  );

  assign pwr_up     = pwr_q;
  assign mode       = state_q.mode;
  assign clk_src_rx = state_q.src_rx;
  assign freq_code  = state_q.freq;
endmodule

// File: rtl/pm_mode_checker.sv
`timescale 1ns/1ps
module pm_mode_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       eval_tick,
  input logic       pwr_up,
  input logic [1:0] mode,
  input logic       clk_src_rx,
  input logic [1:0] freq_code
);
  assert_mode_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

  assert_pwr_agrees_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_up == (mode != 2'b00));

  assert_hold_off_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_tick |=> $stable({pwr_up, mode, clk_src_rx, freq_code}));

  assert_duplex_tx_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> !clk_src_rx);

  assert_down_tx_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> !clk_src_rx);

  assert_freq_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    freq_code != 2'b11);
endmodule

bind pm_clock_mode_ctrl pm_mode_checker u_pm_chk (
  .clk(clk), .rst_n(rst_n), .eval_tick(eval_tick), .pwr_up(pwr_up),
  .mode(mode), .clk_src_rx(clk_src_rx), .freq_code(freq_code)
);

// File: tb/test_pm_clock_mode_ctrl.sv
`timescale 1ns/1ps
module test_pm_clock_mode_ctrl;
  localparam int W      = 16;
  localparam int SETTLE = 5 * W + 12;

  typedef struct {
    string      tag;
    logic [1:0] mode;
    logic       src;
    logic [1:0] freq;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] pins = 4'b0;
  logic       pwr_up, clk_src_rx;
  logic [1:0] mode, freq_code;

  // 0 hold low, 1 hold high, 2 toggle
  int gen_mode [4] = '{0, 0, 0, 0};
  int half_per [4] = '{3, 4, 1, 2};
  int gen_cnt  [4] = '{0, 0, 0, 0};

  exp_t sb_q[$];
  int n_checks = 0;
  int n_fail = 0;
  int mode_changes = 0;
  int illegal_seen = 0;
  logic [1:0] prev_mode = 2'b00;
  bit done = 0;

  always #4 clk = ~clk;

  pm_clock_mode_ctrl #(.WINDOW(W), .SYNC_STAGES(2)) i_pm_clock_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_fsync(pins[0]), .rx_fsync(pins[1]),
    .rx_mclk_pdn(pins[2]), .rx_bclk_sel(pins[3]), .pwr_up(pwr_up),
    .mode(mode), .clk_src_rx(clk_src_rx), .freq_code(freq_code)
  );

  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (gen_mode[i] == 0) pins[i] <= 1'b0;
      else if (gen_mode[i] == 1) pins[i] <= 1'b1;
      else begin
        if (gen_cnt[i] >= half_per[i] - 1) begin
          gen_cnt[i] <= 0;
          pins[i] <= ~pins[i];
        end else gen_cnt[i] <= gen_cnt[i] + 1;
      end
    end
  end

  // port watcher for R8 / R9
  always @(negedge clk) begin
    prev_mode <= mode;
    if (rst_n && mode !== prev_mode) mode_changes++;
    if (rst_n && mode === 2'b11) illegal_seen++;
  end

  // monitor: pops expected items and compares against the ports
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      logic exp_pwr;
      e = sb_q.pop_front();
      exp_pwr = (e.mode != 2'b00);
      n_checks++;
      if (mode !== e.mode || clk_src_rx !== e.src || freq_code !== e.freq || pwr_up !== exp_pwr) begin
        n_fail++;
        $display("FAIL %s: got mode=%b src=%b freq=%b pwr=%b, expected mode=%b src=%b freq=%b pwr=%b",
                 e.tag, mode, clk_src_rx, freq_code, pwr_up, e.mode, e.src, e.freq, exp_pwr);
      end
    end
  end

  task automatic expect_now(input string tag, input logic [1:0] m, input logic s, input logic [1:0] f);
    exp_t e;
    e.tag = tag; e.mode = m; e.src = s; e.freq = f;
    @(posedge clk);
    sb_q.push_back(e);
    @(posedge clk);
    @(posedge clk);
  endtask

  task automatic apply(input string tag, input int tx, input int rx, input int pdn, input int bsel,
                       input logic [1:0] m, input logic s, input logic [1:0] f);
    gen_mode[0] = tx; gen_mode[1] = rx; gen_mode[2] = pdn; gen_mode[3] = bsel;
    repeat (SETTLE) @(posedge clk);
    expect_now(tag, m, s, f);
  endtask

  task automatic check_int(input string tag, input int act, input int exp_v);
    n_checks++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: got %0d, expected %0d", tag, act, exp_v);
    end
  endtask

  initial begin
    int base;
    repeat (3) @(posedge clk);
    expect_now("R1 reset state", 2'b00, 1'b0, 2'b00);
    rst_n = 1'b1;
    expect_now("R1 just after reset", 2'b00, 1'b0, 2'b00);

    apply("R3 duplex pdn low", 2, 2, 0, 2, 2'b01, 1'b0, 2'b00);
    apply("R3 duplex pdn toggling keeps tx clock", 2, 2, 2, 2, 2'b01, 1'b0, 2'b00);
    apply("R3 duplex tx sync only", 2, 0, 0, 2, 2'b01, 1'b0, 2'b00);
    apply("R4 half-channel rx master clock", 0, 2, 2, 2, 2'b10, 1'b1, 2'b00);
    apply("R4 half-channel pdn low", 0, 2, 0, 2, 2'b10, 1'b0, 2'b00);
    apply("R5 pdn static high", 2, 2, 1, 2, 2'b00, 1'b0, 2'b00);
    apply("R6 no frame sync", 0, 0, 0, 2, 2'b00, 1'b0, 2'b00);
    apply("R7 strap low", 2, 2, 0, 0, 2'b01, 1'b0, 2'b01);
    apply("R7 strap high", 2, 2, 0, 1, 2'b01, 1'b0, 2'b10);
    apply("R7 strap high while down (R2 static level)", 0, 0, 0, 1, 2'b00, 1'b0, 2'b10);

    // R8: a short pause on the tx sync is absorbed
    apply("R8 setup duplex", 2, 2, 0, 2, 2'b01, 1'b0, 2'b00);
    base = mode_changes;
    gen_mode[0] = 0;
    repeat (W + 2) @(posedge clk);
    gen_mode[0] = 2;
    repeat (SETTLE) @(posedge clk);
    check_int("R8 short pause causes no mode change", mode_changes - base, 0);
    expect_now("R8 still duplex after pause", 2'b01, 1'b0, 2'b00);

    // R8/R2: a real stop commits no sooner than two windows
    gen_mode[0] = 0;
    repeat (2 * W - 2) @(posedge clk);
    expect_now("R8 not committed before two windows", 2'b01, 1'b0, 2'b00);
    repeat (2 * W + 12) @(posedge clk);
    expect_now("R2 stopped sync seen static, half-channel", 2'b10, 1'b0, 2'b00);

    check_int("R9 illegal mode never seen", illegal_seen, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule